// File: doc/BRIEF.md
# NVM Low-Power Entry and Exit Controller

This block decides, cycle by cycle, whether a non-volatile memory macro sits in its low-power state. It watches a 2-bit policy select, the system standby level, a one-cycle software request to drop into low power, and the bus access request aimed at the macro. It drives the macro's low-power enable and a stall back to the bus that holds an access while the macro is being woken.

The policy select picks one of three behaviours. SEMI: a standby rising edge or the software request puts the macro to sleep, and only an access wakes it. FULL: the same two triggers put it to sleep, and it wakes as soon as standby is low. MANUAL: only the software request puts it to sleep, and an access wakes it. The fourth code is reserved and is treated as MANUAL. A trigger that arrives while an access is in progress is held until the bus goes idle.

The controller is a three-state machine. ACTIVE (macro awake, accesses pass) takes the *enter* transition to SLEEP when a trigger is present and `acc_req` is low. SLEEP (enable high) takes the *rouse* transition to WAKE on an access, or in FULL policy when standby is low. WAKE (enable low, macro settling) takes the *ready* transition back to ACTIVE after `WAKE_CYC` cycles.

Top module: `nvm_lp_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `lp_en` and `acc_stall` are 0, and no trigger is remembered.
- R2: In every policy code, a `sleep_cmd` pulse in a cycle with `lp_en`=0, the machine idle and `acc_req`=0 raises `lp_en` from the next clock edge.
- R3: In policy codes 0 (SEMI) and 1 (FULL), a rising edge of `standby` raises `lp_en` from the next clock edge when `acc_req` is 0.
- R4: In policy code 3 (MANUAL), a rising edge of `standby` leaves `lp_en` at 0.
- R5: In policy codes 0, 2 and 3, `lp_en` stays 1 while `acc_req` is 0, whatever `standby` does.
- R6: In policy code 1 (FULL), `lp_en` falls at the clock edge after a cycle in which it is 1 and `standby` is 0, with no access needed.
- R7: An access (`acc_req`=1) seen while `lp_en`=1 is stalled in that cycle and for the following `WAKE_CYC` cycles; `lp_en` falls at the first edge, and `acc_stall` is 0 in the cycle after the wake period.
- R8: A `sleep_cmd` pulse or qualifying standby edge in a cycle with `acc_req`=1 is held; `lp_en` rises at the edge ending the first later cycle with `acc_req`=0.
- R9: A `sleep_cmd` pulse in a cycle with `lp_en`=1 is dropped: after the next wake-up the macro stays awake.
- R10: Policy code 2 (reserved) behaves exactly as code 3: a standby edge has no effect, the software request enters, an access wakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Policy: 0 SEMI, 1 FULL, 2 reserved (as MANUAL), 3 MANUAL |
| standby | input | 1 | System standby level |
| sleep_cmd | input | 1 | One-cycle software request to enter low power |
| acc_req | input | 1 | Bus access request to the macro, held until granted |
| lp_en | output | 1 | Low-power enable to the macro |
| acc_stall | output | 1 | Holds the current access while the macro wakes |

## Verification
The bench builds the controller with `WAKE_CYC` = 2, so every wake-up completes in three stalled cycles and each policy can be walked through entry, hold and exit in a short vector table. With that value the edge cases sit close together: a FULL exit with an access landing in the last wake cycle, a trigger held across a multi-cycle access, and a second request dropped while asleep, all of which differ from a faulty design within a few cycles.

// File: rtl/nvm_lp_pkg.sv
package nvm_lp_pkg;

    typedef enum logic [1:0] {
        PRM_SEMI   = 2'd0,
        PRM_FULL   = 2'd1,
        PRM_RSVD   = 2'd2,
        PRM_MANUAL = 2'd3
    } prm_e;

    typedef enum logic [1:0] {
        LP_ACTIVE = 2'd0,
        LP_SLEEP  = 2'd1,
        LP_WAKE   = 2'd2
    } lp_state_e;

    // The reserved code falls back to manual policy (R10)
    function automatic prm_e prm_resolve(input logic [1:0] raw);
        prm_e m;
        m = prm_e'(raw);
        if (m == PRM_RSVD) begin
            m = PRM_MANUAL;
        end
        return m;
    endfunction

    function automatic logic prm_standby_enters(input prm_e m);
        return (m == PRM_SEMI) || (m == PRM_FULL);
    endfunction

endpackage

// File: rtl/nvm_lp_trigger.sv
module nvm_lp_trigger
    import nvm_lp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  prm_e mode_eff,
    input  logic standby,
    input  logic sleep_cmd,
    input  logic in_sleep,
    input  logic take,
    output logic enter_req
);

    logic stby_q;
    logic pend_q;
    logic stby_rise;
    logic fresh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stby_q <= 1'b0;
        end else begin
            stby_q <= standby;
        end
    end

    assign stby_rise = standby & ~stby_q;
    assign fresh     = sleep_cmd | (stby_rise & prm_standby_enters(mode_eff));
    assign enter_req = fresh | pend_q;

    // Hold a trigger until the machine takes it; drop it while asleep (R8, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (take || in_sleep) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= enter_req;
        end
    end

endmodule

// File: rtl/nvm_lp_wake_timer.sv
module nvm_lp_wake_timer #(
    parameter int unsigned WAKE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/nvm_lp_ctrl.sv
module nvm_lp_ctrl
    import nvm_lp_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       standby,
    input  logic       sleep_cmd,
    input  logic       acc_req,
    output logic       lp_en,
    output logic       acc_stall
);

    lp_state_e state_q;
    lp_state_e state_d;
    prm_e      mode_eff;
    logic      enter_req;
    logic      take;
    logic      wake_done;

    assign mode_eff = prm_resolve(mode);
    assign take     = (state_q == LP_ACTIVE) && enter_req && !acc_req;

    nvm_lp_trigger u_trigger (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_eff  (mode_eff),
        .standby   (standby),
        .sleep_cmd (sleep_cmd),
        .in_sleep  (state_q == LP_SLEEP),
        .take      (take),
        .enter_req (enter_req)
    );

    nvm_lp_wake_timer #(
        .WAKE_CYC (WAKE_CYC)
    ) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == LP_WAKE),
        .done  (wake_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LP_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_ACTIVE: begin
                if (take) begin
                    state_d = LP_SLEEP;
                end
            end
            LP_SLEEP: begin
                if (acc_req || ((mode_eff == PRM_FULL) && !standby)) begin
                    state_d = LP_WAKE;
                end
            end
            LP_WAKE: begin
                if (wake_done) begin
                    state_d = LP_ACTIVE;
                end
            end
            default: state_d = LP_ACTIVE;
        endcase
    end

    always_comb begin
        lp_en     = (state_q == LP_SLEEP);
        acc_stall = acc_req && (state_q != LP_ACTIVE);
    end

endmodule

// File: rtl/nvm_lp_ctrl_chk.sv
module nvm_lp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       standby,
    input logic       acc_req,
    input logic       lp_en,
    input logic       acc_stall
);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (!lp_en && !acc_stall)
                else $error("outputs active during reset");
        end
    end

    // R7
    stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stall |-> acc_req);

    // R7
    wake_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_en && acc_req) |=> !lp_en);

    // R8
    no_entry_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_en && acc_req) |=> !lp_en);

    // R5
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_en && !acc_req && (mode != 2'd1)) |=> lp_en);

    // R6
    full_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_en && (mode == 2'd1) && !standby) |=> !lp_en);

endmodule

bind nvm_lp_ctrl nvm_lp_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .standby   (standby),
    .acc_req   (acc_req),
    .lp_en     (lp_en),
    .acc_stall (acc_stall)
);

// File: tb/nvm_lp_ctrl_bench.sv
module nvm_lp_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       standby = 1'b0;
    logic       sleep_cmd = 1'b0;
    logic       acc_req = 1'b0;
    logic       lp_en;
    logic       acc_stall;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nvm_lp_ctrl #(.WAKE_CYC(2)) u_nvm_lp_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .standby   (standby),
        .sleep_cmd (sleep_cmd),
        .acc_req   (acc_req),
        .lp_en     (lp_en),
        .acc_stall (acc_stall)
    );

    // {req tag[3:0], mode[1:0], standby, sleep_cmd, acc_req, exp lp_en, exp acc_stall}
    localparam int NV = 51;
    localparam logic [10:0] VEC [NV] = '{
        11'b0001_11_0_0_0_0_0, // R1 idle
        11'b0010_11_0_1_0_0_0, // R2 command
        11'b0010_11_0_0_0_1_0, // R2 asleep
        11'b0101_11_0_0_0_1_0, // R5 held
        11'b0111_11_0_0_1_1_1, // R7 access while asleep
        11'b0111_11_0_0_1_0_1, // R7 wake 1
        11'b0111_11_0_0_1_0_1, // R7 wake 2
        11'b0111_11_0_0_1_0_0, // R7 granted
        11'b0111_11_0_0_0_0_0,
        11'b0100_11_1_0_0_0_0, // R4 standby rise, manual
        11'b0100_11_1_0_0_0_0, // R4 still awake
        11'b0100_11_0_0_0_0_0,
        11'b0011_00_1_0_0_0_0, // R3 semi standby rise
        11'b0011_00_1_0_0_1_0, // R3 asleep
        11'b0101_00_0_0_0_1_0, // R5 standby low, still asleep
        11'b0101_00_0_0_0_1_0,
        11'b0111_00_0_0_1_1_1, // R7
        11'b0111_00_0_0_1_0_1,
        11'b0111_00_0_0_1_0_1,
        11'b0111_00_0_0_1_0_0,
        11'b0111_00_0_0_0_0_0,
        11'b0011_01_1_0_0_0_0, // R3 full standby rise
        11'b0011_01_1_0_0_1_0,
        11'b0110_01_1_0_0_1_0, // R6 stays while standby
        11'b0110_01_0_0_0_1_0, // R6 standby ends
        11'b0110_01_0_0_0_0_0, // R6 awake without access
        11'b0110_01_0_0_0_0_0,
        11'b0110_01_0_0_0_0_0,
        11'b1000_11_0_1_1_0_0, // R8 command during access
        11'b1000_11_0_0_1_0_0,
        11'b1000_11_0_0_0_0_0, // R8 bus idle, entry at this edge
        11'b1000_11_0_0_0_1_0,
        11'b0111_11_0_0_1_1_1,
        11'b0111_11_0_0_1_0_1,
        11'b0111_11_0_0_1_0_1,
        11'b0111_11_0_0_0_0_0,
        11'b1010_10_1_0_0_0_0, // R10 reserved, standby rise ignored
        11'b1010_10_1_0_0_0_0,
        11'b1010_10_0_1_0_0_0, // R10 command
        11'b1010_10_0_0_0_1_0,
        11'b1010_10_0_0_0_1_0, // R10 no exit on standby low
        11'b1010_10_0_0_1_1_1, // R10 access wakes
        11'b1010_10_0_0_1_0_1,
        11'b1010_10_0_0_1_0_1,
        11'b1010_10_0_0_0_0_0,
        11'b0010_01_0_1_0_0_0, // R2 full, command
        11'b0010_01_0_0_0_1_0,
        11'b0110_01_0_0_0_0_0, // R6 left at once
        11'b0111_01_0_0_1_0_1, // R7 access in last wake cycle
        11'b0111_01_0_0_1_0_0,
        11'b0111_01_0_0_0_0_0
    };

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic sb, input logic c, input logic r);
        @(negedge clk);
        mode = m;
        standby = sb;
        sleep_cmd = c;
        acc_req = r;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "lp_en in reset", lp_en, 1'b0);
        chk("R1", "acc_stall in reset", acc_stall, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            string t;
            v = VEC[i];
            step(v[6:5], v[4], v[3], v[2]);
            t = $sformatf("R%0d vec%0d", v[10:7], i);
            chk(t, "lp_en", lp_en, v[1]);
            chk(t, "acc_stall", acc_stall, v[0]);
        end

        // R9: second command while asleep is dropped
        step(2'd3, 1'b0, 1'b1, 1'b0);
        chk("R9", "lp_en before entry", lp_en, 1'b0);
        step(2'd3, 1'b0, 1'b1, 1'b0);
        chk("R9", "lp_en asleep", lp_en, 1'b1);
        step(2'd3, 1'b0, 1'b0, 1'b1);
        chk("R9", "stall on wake", acc_stall, 1'b1);
        step(2'd3, 1'b0, 1'b0, 1'b1);
        step(2'd3, 1'b0, 1'b0, 1'b1);
        step(2'd3, 1'b0, 1'b0, 1'b0);
        chk("R9", "awake after wake", lp_en, 1'b0);
        step(2'd3, 1'b0, 1'b0, 1'b0);
        chk("R9", "no re-entry", lp_en, 1'b0);
        step(2'd3, 1'b0, 1'b0, 1'b0);
        chk("R9", "no re-entry later", lp_en, 1'b0);

        // R8: semi standby edge during an access is held
        step(2'd0, 1'b0, 1'b0, 1'b1);
        chk("R8", "lp_en before edge", lp_en, 1'b0);
        step(2'd0, 1'b1, 1'b0, 1'b1);
        chk("R8", "stall while awake", acc_stall, 1'b0);
        step(2'd0, 1'b1, 1'b0, 1'b1);
        chk("R8", "held during access", lp_en, 1'b0);
        step(2'd0, 1'b1, 1'b0, 1'b0);
        chk("R8", "entry at this edge", lp_en, 1'b0);
        step(2'd0, 1'b1, 1'b0, 1'b0);
        chk("R8", "asleep after access", lp_en, 1'b1);

        // R1: reset from sleep
        @(negedge clk);
        rst_n = 1'b0;
        standby = 1'b0;
        acc_req = 1'b1;
        #1;
        chk("R1", "lp_en in reset from sleep", lp_en, 1'b0);
        chk("R1", "acc_stall in reset", acc_stall, 1'b0);
        @(negedge clk);
        acc_req = 1'b0;
        rst_n = 1'b1;
        step(2'd0, 1'b0, 1'b0, 1'b0);
        chk("R1", "lp_en after reset", lp_en, 1'b0);
        step(2'd0, 1'b0, 1'b0, 1'b0);
        chk("R1", "no remembered trigger", lp_en, 1'b0);

        finish_run();
    end

endmodule